// File: doc/BRIEF.md
# Low-Speed Packet Gap Timer

This block sits in the host-side transmit path of a USB 2.0 controller and runs on the 60 MHz PHY clock. Each time a low-speed packet finishes, whether received or sent, it holds off the next low-speed transmission for a programmable gap. Two gaps are kept apart. The receive-to-transmit gap (turnaround) follows the end of a received packet. The transmit-to-transmit gap (inter-packet) follows the end of a sent packet. Each gap is chosen by its own 3-bit code. The transmit scheduler starts a low-speed packet only while `tx_ready_o` is high.

A code value c selects a gap of 2 + c/2 low-speed bit times. One low-speed bit lasts 40 PHY clocks, so the gap is 80 + 20·c clocks. The gap therefore ranges from 80 clocks for code 0 to 220 clocks for code 7. The block adds no allowance for the PHY's own transmit-end delay; software folds that into the codes it programs. In device mode the timer is bypassed.

Top module: `ls_gap_timer`

## Requirements
- R1: After reset is released with host mode selected and no end-of-packet pulse seen, `tx_ready_o` is high.
- R2: An `rx_eop_i` pulse sampled in host mode drives `tx_ready_o` low from that clock edge. It rises again at the (80 + 20·`turn_code_i`)-th rising edge after the sampling edge. The code is the 3-bit unsigned value present when the pulse is sampled.
- R3: A `tx_eop_i` pulse sampled in host mode behaves in the same way, with a gap of 80 + 20·`ipg_code_i` edges.
- R4: Once `tx_ready_o` is high in host mode, it stays high until the next end-of-packet pulse.
- R5: An end-of-packet pulse that arrives while a gap is running restarts the count from zero. The new count uses the gap for the new pulse's direction.
- R6: A gap code that changes while a gap is running has no effect on that gap.
- R7: When `host_mode_i` is low, `tx_ready_o` is high in the same cycle and end-of-packet pulses are ignored. Leaving host mode drops any running gap, so `tx_ready_o` is still high on return to host mode.
- R8: When `rx_eop_i` and `tx_eop_i` are sampled high on the same edge, the turnaround gap (from `turn_code_i`) is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 60 MHz PHY clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_mode_i | input | 1 | 1 = host mode (gaps enforced), 0 = device mode (bypass) |
| turn_code_i | input | 3 | Receive-to-transmit gap code |
| ipg_code_i | input | 3 | Transmit-to-transmit gap code |
| rx_eop_i | input | 1 | One-cycle pulse at the end of a received low-speed packet |
| tx_eop_i | input | 1 | One-cycle pulse at the end of a transmitted low-speed packet |
| tx_ready_o | output | 1 | High when a low-speed transmission may start |

## Verification
Call the edge that samples a pulse edge 0. `tx_ready_o` falls at edge 0 and rises at edge 80 + 20·c. The bench drives inputs on falling edges and reads the output on falling edges. It counts falling edges from the release of the pulse until the flag is seen high, so the count equals the gap in clocks exactly. Device-mode bypass is combinational, so the bench checks it one nanosecond after changing `host_mode_i`. In the checker, a reference counter records the gap expected at each sampled pulse. The checker then requires every rise of the flag to land on exactly that edge.

// File: rtl/ls_gap_pkg.sv
package ls_gap_pkg;

    // Default geometry of the low-speed gap
    localparam int unsigned CODE_W       = 3;   // width of each gap code
    localparam int unsigned CLK_PER_HALF = 20;  // PHY clocks per half bit time
    localparam int unsigned BASE_HALVES  = 4;   // gap for code 0, in half bit times

    // Which gap a pulse selects
    typedef enum logic {
        DIR_TURN = 1'b0,
        DIR_IPG  = 1'b1
    } gap_dir_e;

endpackage

// File: rtl/ls_gap_len.sv
module ls_gap_len #(
    parameter int unsigned CODE_W       = ls_gap_pkg::CODE_W,
    parameter int unsigned CLK_PER_HALF = ls_gap_pkg::CLK_PER_HALF,
    parameter int unsigned BASE_HALVES  = ls_gap_pkg::BASE_HALVES,
    parameter int unsigned CNT_W        = 8
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [CNT_W-1:0]  len_m1_o
);

    // Gap in clocks minus one: terminal count for a down-counter ending at zero
    always_comb begin
        len_m1_o = CNT_W'((BASE_HALVES + int'(code_i)) * CLK_PER_HALF - 1);
    end

endmodule

// File: rtl/ls_gap_ctr.sv
module ls_gap_ctr #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             ready_o
);

    typedef struct packed {
        logic             ready;
        logic [CNT_W-1:0] cnt;
    } ctr_state_t;

    ctr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!enable_i) begin
            st_d.ready = 1'b1;
            st_d.cnt   = '0;
        end else if (load_i) begin
            st_d.ready = 1'b0;
            st_d.cnt   = load_val_i;
        end else if (!st_q.ready) begin
            if (st_q.cnt == '0) begin
                st_d.ready = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ready: 1'b1, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ready_o = st_q.ready | ~enable_i;

endmodule

// File: rtl/ls_gap_timer.sv
module ls_gap_timer #(
    parameter int unsigned CODE_W       = ls_gap_pkg::CODE_W,
    parameter int unsigned CLK_PER_HALF = ls_gap_pkg::CLK_PER_HALF,
    parameter int unsigned BASE_HALVES  = ls_gap_pkg::BASE_HALVES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_mode_i,
    input  logic [CODE_W-1:0] turn_code_i,
    input  logic [CODE_W-1:0] ipg_code_i,
    input  logic              rx_eop_i,
    input  logic              tx_eop_i,
    output logic              tx_ready_o
);

    import ls_gap_pkg::*;

    localparam int unsigned MAX_CLKS = (BASE_HALVES + (1 << CODE_W) - 1) * CLK_PER_HALF;
    localparam int unsigned CNT_W    = $clog2(MAX_CLKS);
    localparam int unsigned N_DIR    = 2;

    logic [N_DIR-1:0][CODE_W-1:0] code_v;
    logic [N_DIR-1:0][CNT_W-1:0]  len_m1_v;
    gap_dir_e                     dir;
    logic                         load;
    logic [CNT_W-1:0]             load_val;

    assign code_v[DIR_TURN] = turn_code_i;
    assign code_v[DIR_IPG]  = ipg_code_i;

    for (genvar g = 0; g < N_DIR; g++) begin : g_len
        ls_gap_len #(
            .CODE_W       (CODE_W),
            .CLK_PER_HALF (CLK_PER_HALF),
            .BASE_HALVES  (BASE_HALVES),
            .CNT_W        (CNT_W)
        ) u_len (
            .code_i   (code_v[g]),
            .len_m1_o (len_m1_v[g])
        );
    end

    // Receive end wins a tie: the turnaround gap applies
    always_comb begin
        dir      = rx_eop_i ? DIR_TURN : DIR_IPG;
        load     = rx_eop_i | tx_eop_i;
        load_val = len_m1_v[dir];
    end

    ls_gap_ctr #(
        .CNT_W (CNT_W)
    ) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (host_mode_i),
        .load_i     (load),
        .load_val_i (load_val),
        .ready_o    (tx_ready_o)
    );

endmodule

// File: rtl/ls_gap_timer_chk.sv
module ls_gap_timer_chk #(
    parameter int unsigned CODE_W       = ls_gap_pkg::CODE_W,
    parameter int unsigned CLK_PER_HALF = ls_gap_pkg::CLK_PER_HALF,
    parameter int unsigned BASE_HALVES  = ls_gap_pkg::BASE_HALVES
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_mode_i,
    input logic [CODE_W-1:0] turn_code_i,
    input logic [CODE_W-1:0] ipg_code_i,
    input logic              rx_eop_i,
    input logic              tx_eop_i,
    input logic              tx_ready_o
);

    logic [15:0] exp_q;
    logic [15:0] el_q;
    logic        eop;

    assign eop = rx_eop_i | tx_eop_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_q <= '0;
            el_q  <= '0;
        end else if (host_mode_i && eop) begin
            el_q  <= '0;
            exp_q <= rx_eop_i ? 16'((BASE_HALVES + int'(turn_code_i)) * CLK_PER_HALF)
                              : 16'((BASE_HALVES + int'(ipg_code_i)) * CLK_PER_HALF);
        end else if (el_q != 16'hFFFF) begin
            el_q <= el_q + 16'd1;
        end
    end

    AST_DROP_ON_EOP: assert property (@(posedge clk) disable iff (!rst_n)
        host_mode_i && eop |=> !tx_ready_o || !host_mode_i); // R2

    AST_RISE_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        host_mode_i && $past(host_mode_i) && $rose(tx_ready_o) |-> el_q == exp_q); // R5

    AST_READY_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        host_mode_i && tx_ready_o && !eop |=> tx_ready_o); // R4

    AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        host_mode_i && !tx_ready_o && !eop && (32'(el_q) + 1 < 32'(exp_q))
        |=> !tx_ready_o || !host_mode_i); // R6

endmodule

bind ls_gap_timer ls_gap_timer_chk #(
    .CODE_W       (CODE_W),
    .CLK_PER_HALF (CLK_PER_HALF),
    .BASE_HALVES  (BASE_HALVES)
) i_ls_gap_timer_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_mode_i (host_mode_i),
    .turn_code_i (turn_code_i),
    .ipg_code_i  (ipg_code_i),
    .rx_eop_i    (rx_eop_i),
    .tx_eop_i    (tx_eop_i),
    .tx_ready_o  (tx_ready_o)
);

// File: tb/test_ls_gap_timer.sv
module test_ls_gap_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_mode_i = 1'b1;
    logic [2:0] turn_code_i = 3'd0;
    logic [2:0] ipg_code_i = 3'd2;
    logic       rx_eop_i = 1'b0;
    logic       tx_eop_i = 1'b0;
    logic       tx_ready_o;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    ls_gap_timer i_ls_gap_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_mode_i (host_mode_i),
        .turn_code_i (turn_code_i),
        .ipg_code_i  (ipg_code_i),
        .rx_eop_i    (rx_eop_i),
        .tx_eop_i    (tx_eop_i),
        .tx_ready_o  (tx_ready_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // One-cycle pulse; returns between the sampling edge and the next one
    task automatic pulse(input logic rx, input logic tx);
        @(negedge clk);
        rx_eop_i = rx;
        tx_eop_i = tx;
        @(negedge clk);
        rx_eop_i = 1'b0;
        tx_eop_i = 1'b0;
    endtask

    // Edges after the sampling edge until the flag is seen high
    task automatic measure(output int n);
        n = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            n++;
            if (tx_ready_o) break;
        end
    endtask

    task automatic t_reset();
        check(tx_ready_o == 1'b1, "R1 ready after reset", int'(tx_ready_o), 1);
    endtask

    task automatic t_turn(input int code);
        int n;
        @(negedge clk);
        turn_code_i = 3'(code);
        ipg_code_i  = 3'(7 - code);
        pulse(1'b1, 1'b0);
        check(tx_ready_o == 1'b0, "R2 ready drops on rx end", int'(tx_ready_o), 0);
        measure(n);
        check(n == 80 + 20 * code, "R2 turnaround gap", n, 80 + 20 * code);
    endtask

    task automatic t_ipg(input int code);
        int n;
        @(negedge clk);
        ipg_code_i  = 3'(code);
        turn_code_i = 3'(7 - code);
        pulse(1'b0, 1'b1);
        check(tx_ready_o == 1'b0, "R3 ready drops on tx end", int'(tx_ready_o), 0);
        measure(n);
        check(n == 80 + 20 * code, "R3 inter-packet gap", n, 80 + 20 * code);
    endtask

    task automatic t_sticky();
        int lows = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (!tx_ready_o) lows++;
        end
        check(lows == 0, "R4 ready stays high", lows, 0);
    endtask

    task automatic t_restart();
        int n;
        @(negedge clk);
        turn_code_i = 3'd0;
        ipg_code_i  = 3'd5;
        pulse(1'b1, 1'b0);
        repeat (30) @(negedge clk);
        check(tx_ready_o == 1'b0, "R5 still counting", int'(tx_ready_o), 0);
        pulse(1'b0, 1'b1);
        measure(n);
        check(n == 180, "R5 restart with new direction", n, 180);
    endtask

    task automatic t_code_change();
        int n;
        @(negedge clk);
        ipg_code_i = 3'd1;
        pulse(1'b0, 1'b1);
        repeat (10) @(negedge clk);
        ipg_code_i  = 3'd7;
        turn_code_i = 3'd7;
        measure(n);
        check(n + 10 == 100, "R6 code change mid gap", n + 10, 100);
    endtask

    task automatic t_device();
        int lows = 0;
        @(negedge clk);
        host_mode_i = 1'b0;
        #1;
        check(tx_ready_o == 1'b1, "R7 ready in device mode", int'(tx_ready_o), 1);
        turn_code_i = 3'd7;
        pulse(1'b1, 1'b0);
        for (int i = 0; i < 100; i++) begin
            if (!tx_ready_o) lows++;
            @(negedge clk);
        end
        check(lows == 0, "R7 pulses ignored in device mode", lows, 0);
        host_mode_i = 1'b1;
        #1;
        check(tx_ready_o == 1'b1, "R7 ready on return to host", int'(tx_ready_o), 1);
        pulse(1'b1, 1'b0);
        repeat (20) @(negedge clk);
        check(tx_ready_o == 1'b0, "R7 counting before bypass", int'(tx_ready_o), 0);
        host_mode_i = 1'b0;
        #1;
        check(tx_ready_o == 1'b1, "R7 bypass mid gap", int'(tx_ready_o), 1);
        @(negedge clk);
        host_mode_i = 1'b1;
        #1;
        check(tx_ready_o == 1'b1, "R7 running gap dropped", int'(tx_ready_o), 1);
    endtask

    task automatic t_tie();
        int n;
        @(negedge clk);
        turn_code_i = 3'd1;
        ipg_code_i  = 3'd6;
        pulse(1'b1, 1'b1);
        measure(n);
        check(n == 100, "R8 tie uses turnaround gap", n, 100);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_turn(0);
        t_turn(3);
        t_turn(7);
        t_ipg(0);
        t_ipg(2);
        t_ipg(7);
        t_sticky();
        t_restart();
        t_code_change();
        t_device();
        t_tie();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule